// File: doc/BRIEF.md
# Low-Speed USB Receive Deserializer

This block turns the differential line pair of a 1.5 Mbit/s USB link into a stream of packet bytes. It runs from a clock that is a fixed multiple of the bit rate, brings both line inputs into its own clock domain, and re-centres its bit sampling point on every change of D+. A rising edge of D+ from idle starts a search for the synchronisation field. Once the field has closed, the block reverses the NRZI line coding, drops the bits the transmitter stuffed, and shifts data in least significant bit first.

Each finished byte leaves on a one-cycle beat together with a mask. The mask marks the bit positions in front of which a stuffed bit was removed. A packet ends with a one-cycle done pulse that carries the count of whole bytes delivered and two flags: one for a packet longer than the configured byte limit, one for a malformed line sequence. CRC checking and PID decoding are left to the consumer. The first byte delivered is the PID.

The line cannot be paused, so the byte stream has no back-pressure. There is no ready input. A consumer must take every beat in the cycle in which `byte_valid` is high. The data and mask stay unchanged until the next beat.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, `byte_valid`, `pkt_done`, `pkt_overflow`, `pkt_error` and `rx_active` are low and `pkt_len` is zero.
- R2: The idle level (J) is D+ low with D- high, and K is D+ high with D- low. Line bits are sampled half a bit period after the most recent D+ change. A sample equal to the previous line level decodes as 1 and a changed level decodes as 0. The first decoded bit lands in `byte_data` bit 0.
- R3: Reception starts on a rising edge of D+ while idle. The sync field is K J K J K J K K. It closes on the first pair of consecutive K samples, provided at least MIN_SYNC_BITS samples (the closing one included) have been taken. The next bit is data bit 0 of the PID. A new packet may follow one idle bit after the previous end of packet.
- R4: During the sync search, two consecutive J samples, or a K pair closing before MIN_SYNC_BITS samples, are a false start. The block returns to idle and produces no beat and no done pulse.
- R5: After six consecutive decoded ones, the next line bit is dropped and is not shifted into the byte. The count of ones carries across byte boundaries. The final sync bit counts as the first one.
- R6: `byte_stuff` bit k is set when a stuffed bit was removed directly in front of data bit k of that byte. A stuffed bit that follows bit 7 tags bit 0 of the next byte.
- R7: If the line level does not change in a stuffed-bit slot, the block pulses `pkt_done` with `pkt_error` set and `pkt_len` equal to the bytes already delivered. It then delivers nothing more until an SE0 (both lines low) is seen.
- R8: Two consecutive SE0 samples end a packet with `pkt_done`, both flags low, and `pkt_len` equal to the number of whole bytes. Trailing partial bits are discarded. A single SE0 sample followed by J or K ends the packet with `pkt_error` set.
- R9: A byte that would exceed MAX_BYTES is not delivered. `pkt_done` pulses with `pkt_overflow` set and `pkt_len` equal to MAX_BYTES, and the block ignores the line until an SE0.
- R10: `pkt_done` and `byte_valid` each last one cycle, never coincide, and `pkt_len` equals the number of beats since the previous done pulse.
- R11: `rx_active` is high from the start edge until the packet is finished. It is still high at a done pulse only when that pulse carries a flag. Beats occur only while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line sampling clock, OSR times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_dp | input | 1 | D+ line level, asynchronous |
| line_dm | input | 1 | D- line level, asynchronous |
| byte_valid | output | 1 | One-cycle beat for a received byte, no back-pressure |
| byte_data | output | 8 | Received byte, first bit on the wire in bit 0 |
| byte_stuff | output | 8 | Positions in front of which a stuffed bit was removed |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| pkt_len | output | LEN_W | Whole bytes delivered in the finished packet |
| pkt_overflow | output | 1 | Finished packet exceeded MAX_BYTES |
| pkt_error | output | 1 | Finished packet had a stuffing or SE0 violation |
| rx_active | output | 1 | Receiver is busy with a packet |

## Verification
The byte-limit decision and the completion of the byte that breaks the limit fall on the same bit strobe. In that strobe the receiver must pick between a beat and an overflow done pulse. The bench forces this case with a packet two bytes longer than MAX_BYTES. It then expects exactly MAX_BYTES beats, followed by one done pulse with the overflow flag and the limit as length, and no later beat. A stuffed slot that falls right after bit 7 puts a beat and a stuffing event on neighbouring strobes. This is judged through the bit-0 mask tag of the byte that follows.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SYNC,
    RX_DATA,
    RX_DRAIN
  } rx_state_e;

  typedef struct packed {
    logic dp;
    logic dm;
  } line_t;

  localparam int unsigned STUFF_RUN = 6;
  localparam int unsigned BYTE_W    = 8;

endpackage

// File: rtl/lsrx_line_sync.sv
module lsrx_line_sync
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_t line_in,
  output line_t line_s,
  output logic  dp_edge,
  output logic  dp_rise
);

  logic [STAGES-1:0] dp_pipe;
  logic [STAGES-1:0] dm_pipe;
  logic              dp_prev;

  // Each stage is its own flop pair; the idle J level is the reset value.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dp_pipe[0] <= 1'b0;
          dm_pipe[0] <= 1'b1;
        end else begin
          dp_pipe[0] <= line_in.dp;
          dm_pipe[0] <= line_in.dm;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dp_pipe[g] <= 1'b0;
          dm_pipe[g] <= 1'b1;
        end else begin
          dp_pipe[g] <= dp_pipe[g-1];
          dm_pipe[g] <= dm_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dp_prev <= 1'b0;
    else        dp_prev <= dp_pipe[STAGES-1];
  end

  assign line_s.dp = dp_pipe[STAGES-1];
  assign line_s.dm = dm_pipe[STAGES-1];
  assign dp_edge   = dp_pipe[STAGES-1] ^ dp_prev;
  assign dp_rise   = dp_pipe[STAGES-1] & ~dp_prev;

endmodule

// File: rtl/lsrx_bit_timer.sv
module lsrx_bit_timer #(
  parameter int unsigned OSR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  output logic strobe
);

  localparam int unsigned PW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [PW-1:0] HALF = PW'(OSR / 2);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);

  logic [PW-1:0] phase;

  // The cycle that shows a D+ change counts as phase 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (edge_in)        phase <= PW'(1);
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign strobe = !edge_in && (phase == HALF);

endmodule

// File: rtl/lsrx_bit_unpack.sv
module lsrx_bit_unpack
  import usb_ls_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              bit_en,
  input  logic              level,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_out,
  output logic [BYTE_W-1:0] mask_out,
  output logic              stuff_err
);

  localparam int unsigned IW = $clog2(BYTE_W);
  localparam int unsigned OW = $clog2(STUFF_RUN + 1);
  localparam logic [OW-1:0] RUN_V  = OW'(STUFF_RUN);
  localparam logic [IW-1:0] LAST_I = IW'(BYTE_W - 1);

  logic              last_lvl;
  logic [OW-1:0]     ones;
  logic [IW-1:0]     idx;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] mask_acc;
  logic              dec;
  logic              stuff_slot;

  assign dec        = (level == last_lvl);
  assign stuff_slot = (ones == RUN_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_lvl <= 1'b0;
      ones     <= '0;
      idx      <= '0;
      shreg    <= '0;
      mask_acc <= '0;
    end else if (init) begin
      // The sync field ends on K and its last decoded bit is a one.
      last_lvl <= 1'b1;
      ones     <= OW'(1);
      idx      <= '0;
      shreg    <= '0;
      mask_acc <= '0;
    end else if (bit_en) begin
      last_lvl <= level;
      if (stuff_slot) begin
        ones          <= '0;
        mask_acc[idx] <= 1'b1;
      end else begin
        shreg <= {dec, shreg[BYTE_W-1:1]};
        ones  <= dec ? ones + 1'b1 : '0;
        idx   <= (idx == LAST_I) ? '0 : idx + 1'b1;
        if (idx == LAST_I) mask_acc <= '0;
      end
    end
  end

  assign byte_done = bit_en && !stuff_slot && (idx == LAST_I);
  assign byte_out  = {dec, shreg[BYTE_W-1:1]};
  assign mask_out  = mask_acc;
  assign stuff_err = bit_en && stuff_slot && dec;

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned OSR           = 8,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned MAX_BYTES     = 11,
  parameter int unsigned MIN_SYNC_BITS = 4,
  localparam int unsigned LEN_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_dp,
  input  logic             line_dm,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [7:0]       byte_stuff,
  output logic             pkt_done,
  output logic [LEN_W-1:0] pkt_len,
  output logic             pkt_overflow,
  output logic             pkt_error,
  output logic             rx_active
);

  localparam int unsigned SYNC_W = $clog2(MIN_SYNC_BITS + 1);
  localparam logic [SYNC_W-1:0] SYNC_SAT = SYNC_W'(MIN_SYNC_BITS);
  localparam logic [LEN_W-1:0]  LIMIT    = LEN_W'(MAX_BYTES);

  line_t       line_raw;
  line_t       line_s;
  logic        dp_edge;
  logic        dp_rise;
  logic        strobe;
  logic        se0;

  rx_state_e   state;
  logic [SYNC_W-1:0] sync_cnt;
  logic        prev_k;
  logic        se0_seen;
  logic [LEN_W-1:0] byte_cnt;

  logic        sync_ok;
  logic        asm_init;
  logic        bit_en;
  logic        asm_done;
  logic [7:0]  asm_byte;
  logic [7:0]  asm_mask;
  logic        asm_err;

  assign line_raw.dp = line_dp;
  assign line_raw.dm = line_dm;

  lsrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_raw),
    .line_s  (line_s),
    .dp_edge (dp_edge),
    .dp_rise (dp_rise)
  );

  lsrx_bit_timer #(.OSR(OSR)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_in (dp_edge),
    .strobe  (strobe)
  );

  assign se0      = !line_s.dp && !line_s.dm;
  assign sync_ok  = (int'(sync_cnt) + 1) >= int'(MIN_SYNC_BITS);
  assign asm_init = (state == RX_SYNC) && strobe && line_s.dp && prev_k && sync_ok;
  assign bit_en   = (state == RX_DATA) && strobe && !se0 && !se0_seen;

  lsrx_bit_unpack u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (asm_init),
    .bit_en    (bit_en),
    .level     (line_s.dp),
    .byte_done (asm_done),
    .byte_out  (asm_byte),
    .mask_out  (asm_mask),
    .stuff_err (asm_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= RX_IDLE;
      sync_cnt     <= '0;
      prev_k       <= 1'b0;
      se0_seen     <= 1'b0;
      byte_cnt     <= '0;
      byte_valid   <= 1'b0;
      byte_data    <= '0;
      byte_stuff   <= '0;
      pkt_done     <= 1'b0;
      pkt_len      <= '0;
      pkt_overflow <= 1'b0;
      pkt_error    <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      pkt_done   <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (dp_rise) begin
            state    <= RX_SYNC;
            prev_k   <= 1'b0;
            sync_cnt <= '0;
          end
        end
        RX_SYNC: begin
          if (strobe) begin
            if (line_s.dp && prev_k) begin
              if (sync_ok) begin
                state    <= RX_DATA;
                byte_cnt <= '0;
                se0_seen <= 1'b0;
              end else begin
                state <= RX_IDLE;
              end
            end else if (!line_s.dp && !prev_k) begin
              state <= RX_IDLE;
            end else begin
              prev_k <= line_s.dp;
              if (sync_cnt != SYNC_SAT) sync_cnt <= sync_cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (strobe) begin
            if (se0) begin
              if (se0_seen) begin
                state        <= RX_IDLE;
                pkt_done     <= 1'b1;
                pkt_len      <= byte_cnt;
                pkt_overflow <= 1'b0;
                pkt_error    <= 1'b0;
              end else begin
                se0_seen <= 1'b1;
              end
            end else if (se0_seen || asm_err) begin
              state        <= RX_DRAIN;
              pkt_done     <= 1'b1;
              pkt_len      <= byte_cnt;
              pkt_overflow <= 1'b0;
              pkt_error    <= 1'b1;
            end else if (asm_done) begin
              if (byte_cnt == LIMIT) begin
                state        <= RX_DRAIN;
                pkt_done     <= 1'b1;
                pkt_len      <= byte_cnt;
                pkt_overflow <= 1'b1;
                pkt_error    <= 1'b0;
              end else begin
                byte_valid <= 1'b1;
                byte_data  <= asm_byte;
                byte_stuff <= asm_mask;
                byte_cnt   <= byte_cnt + 1'b1;
              end
            end
          end
        end
        RX_DRAIN: begin
          if (se0) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign rx_active = (state != RX_IDLE);

endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int unsigned MAX_BYTES = 11,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic             pkt_done,
  input logic [LEN_W-1:0] pkt_len,
  input logic             pkt_overflow,
  input logic             pkt_error,
  input logic             rx_active
);

  logic [LEN_W:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        beats <= '0;
    else if (pkt_done)                 beats <= '0;
    else if (byte_valid && !(&beats))  beats <= beats + 1'b1;
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  assert_beat_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_done_beat_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && byte_valid));

  assert_len_matches_beats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> ({1'b0, pkt_len} == beats));

  assert_overflow_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_overflow) |-> (pkt_len == LEN_W'(MAX_BYTES)));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> !(pkt_overflow && pkt_error));

  assert_beat_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> rx_active);

  assert_done_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (rx_active == (pkt_overflow || pkt_error)));

endmodule

bind usb_ls_rx usb_ls_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_valid   (byte_valid),
  .pkt_done     (pkt_done),
  .pkt_len      (pkt_len),
  .pkt_overflow (pkt_overflow),
  .pkt_error    (pkt_error),
  .rx_active    (rx_active)
);

// File: tb/usb_ls_rx_bench.sv
module usb_ls_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 8;
  localparam int MAX_BYTES  = 11;
  localparam int MIN_SYNC   = 4;
  localparam int LEN_W      = $clog2(MAX_BYTES + 1);
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line_dp = 1'b0;
  logic             line_dm = 1'b1;
  logic             byte_valid;
  logic [7:0]       byte_data;
  logic [7:0]       byte_stuff;
  logic             pkt_done;
  logic [LEN_W-1:0] pkt_len;
  logic             pkt_overflow;
  logic             pkt_error;
  logic             rx_active;

  int checks = 0;
  int fails  = 0;
  int beats  = 0;
  int pkts   = 0;
  bit finished = 1'b0;

  logic [15:0] exp_b[$];
  string       exp_bt[$];
  logic [15:0] exp_p[$];
  string       exp_pt[$];
  logic [7:0]  pk [0:15];

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_ls_rx #(
    .OSR(OSR), .SYNC_STAGES(2), .MAX_BYTES(MAX_BYTES), .MIN_SYNC_BITS(MIN_SYNC)
  ) u_usb_ls_rx (
    .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_stuff(byte_stuff),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_overflow(pkt_overflow),
    .pkt_error(pkt_error), .rx_active(rx_active)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares every beat and done pulse with the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (byte_valid) begin
        beats++;
        if (exp_b.size() == 0)
          check(1'b0, "R10", "unexpected byte beat", {byte_data, byte_stuff}, 0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_b.pop_front();
          t = exp_bt.pop_front();
          check({byte_data, byte_stuff} == e, t, "byte data/stuff mask",
                {byte_data, byte_stuff}, e);
        end
      end
      if (pkt_done) begin
        pkts++;
        if (exp_p.size() == 0)
          check(1'b0, "R10", "unexpected done pulse", int'(pkt_len), 0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_p.pop_front();
          t = exp_pt.pop_front();
          check({pkt_overflow, pkt_error, 6'd0, 8'(pkt_len)} == e, t,
                "done ovf/err/len", {pkt_overflow, pkt_error, 6'd0, 8'(pkt_len)}, e);
        end
      end
    end
  end

  task automatic drive_line(input bit dp, input bit dm);
    line_dp = dp;
    line_dm = dm;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic drive_lvl(input bit l);
    drive_line(l, !l);
  endtask

  // Driver: models encoding and pushes the expected items before driving.
  task automatic send_pkt(input int n, input int err_byte, input int extra,
                          input bit short_eop, input string tag);
    bit lvq[$];
    bit lvl = 1'b1;
    int ones = 1;
    bit pend = 1'b0;
    bit injected = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] msk = '0;
      for (int k = 0; k < 8; k++) begin
        if (pend) begin msk[k] = 1'b1; pend = 1'b0; end
        if (pk[i][k]) ones++;
        else begin lvl = !lvl; ones = 0; end
        lvq.push_back(lvl);
        if (ones == 6) begin
          if (i == err_byte && !injected) begin
            injected = 1'b1;
            lvq.push_back(lvl);
          end else begin
            lvl = !lvl;
            lvq.push_back(lvl);
            pend = 1'b1;
          end
          ones = 0;
        end
      end
      if (i < MAX_BYTES && (err_byte < 0 || i < err_byte)) begin
        exp_b.push_back({pk[i], msk});
        exp_bt.push_back(tag);
      end
    end
    for (int x = 0; x < extra; x++) begin
      lvl = !lvl;
      lvq.push_back(lvl);
    end
    if (err_byte >= 0)       exp_p.push_back({2'b01, 6'd0, 8'(err_byte)});
    else if (short_eop)      exp_p.push_back({2'b01, 6'd0, 8'(n)});
    else if (n > MAX_BYTES)  exp_p.push_back({2'b10, 6'd0, 8'(MAX_BYTES)});
    else                     exp_p.push_back({2'b00, 6'd0, 8'(n)});
    exp_pt.push_back(tag);

    for (int s = 0; s < 8; s++) drive_lvl((s % 2 == 0) || (s == 7));
    check(rx_active == 1'b1, "R11", "active after sync", int'(rx_active), 1);
    foreach (lvq[j]) drive_lvl(lvq[j]);
    if (short_eop) begin
      drive_line(1'b0, 1'b0);
      drive_lvl(1'b0);
      drive_lvl(1'b0);
    end
    drive_line(1'b0, 1'b0);
    drive_line(1'b0, 1'b0);
    drive_lvl(1'b0);
    check(rx_active == 1'b0, "R11", "idle after packet", int'(rx_active), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int b0;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(!byte_valid && !pkt_done && !pkt_overflow && !pkt_error && !rx_active
          && pkt_len == '0, "R1", "reset outputs",
          {byte_valid, pkt_done, pkt_overflow, pkt_error, rx_active}, 0);
    repeat (3) drive_lvl(1'b0);

    // R2: plain packet
    pk[0] = 8'hC3; pk[1] = 8'h12; pk[2] = 8'h5A;
    send_pkt(3, -1, 0, 1'b0, "R2");

    // R4: false starts produce nothing
    b0 = beats; p0 = pkts;
    drive_lvl(1'b1); drive_lvl(1'b0); drive_lvl(1'b0); drive_lvl(1'b0);
    drive_lvl(1'b1); drive_lvl(1'b1); drive_lvl(1'b0); drive_lvl(1'b0); drive_lvl(1'b0);
    check(rx_active == 1'b0, "R4", "idle after false starts", int'(rx_active), 0);
    check(beats == b0 && pkts == p0, "R4", "no output on false start",
          beats + pkts, b0 + p0);

    // R3: packet after false starts, then back to back with one idle bit
    pk[0] = 8'h69; pk[1] = 8'h81;
    send_pkt(2, -1, 0, 1'b0, "R3");
    pk[0] = 8'h2D; pk[1] = 8'h00; pk[2] = 8'hE7;
    send_pkt(3, -1, 0, 1'b0, "R3");

    // R5 and R6: long runs of ones, stuffed slot right after bit 7
    pk[0] = 8'hFC; pk[1] = 8'h01; pk[2] = 8'hFF; pk[3] = 8'hFF; pk[4] = 8'h7E;
    send_pkt(5, -1, 0, 1'b0, "R5");
    pk[0] = 8'h1F; pk[1] = 8'hF8; pk[2] = 8'h3F;
    send_pkt(3, -1, 0, 1'b0, "R6");

    // R7: missing toggle in a stuffed slot
    pk[0] = 8'hA5; pk[1] = 8'hFF; pk[2] = 8'h00;
    send_pkt(3, 1, 0, 1'b0, "R7");

    // R8: partial trailing bits and a single-bit SE0
    pk[0] = 8'h4B; pk[1] = 8'h96;
    send_pkt(2, -1, 3, 1'b0, "R8");
    pk[0] = 8'h33;
    send_pkt(1, -1, 0, 1'b1, "R8");

    // R9: two bytes beyond the limit
    for (int i = 0; i < MAX_BYTES + 2; i++) pk[i] = 8'(i * 29 + 3);
    send_pkt(MAX_BYTES + 2, -1, 0, 1'b0, "R9");

    repeat (4) drive_lvl(1'b0);
    check(exp_b.size() == 0, "R10", "bytes left unseen", exp_b.size(), 0);
    check(exp_p.size() == 0, "R10", "done pulses left unseen", exp_p.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule